// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Receiver with Address Filtering

This block takes an asynchronous serial line and turns it into stored bytes. Each bit is timed by a 16x oversampling tick that arrives from outside. Frames carry 8 or 9 data bits and are sent least significant bit first. Each finished frame goes into a two-entry receive queue. The queue holds the data byte, the ninth bit and a framing-error marker for that frame. An interrupt request stays high as long as the queue holds anything. Software pops the head entry with a one-cycle read strobe.

A small control word turns the port on, selects the frame size, enables continuous reception and enables address filtering. In 9-bit mode with address filtering on, only frames whose ninth bit is 1 are kept. This lets a multidrop bus wake a node only for address frames. The same status word reports the framing error of the head entry, the overrun condition and the head entry's ninth bit. Overrun stops all further loading, and only turning off continuous reception clears it.

Top module: `uart9_rx`

## Requirements
- R1: After reset, reg_rdata bits 5:0 read 0 and irq is low. The reg_rdata layout is: bit0 port enable, bit1 nine-bit mode, bit2 continuous receive, bit3 address filter, bit4 framing error of head entry, bit5 overrun, bit6 ninth bit of head entry, bit7 zero. Writing reg_wdata stores bits 3:0 into the control bits.
- R2: Frames are captured only while both the port enable and the continuous-receive bit are 1. If either is 0, activity on rx_in loads nothing.
- R3: With bit1 = 0, a frame has one low start bit, 8 data bits sent LSB first and one stop bit. The byte appears on rx_data at the queue head.
- R4: With bit1 = 1, a frame carries 9 data bits. The ninth bit is stored with its byte and reads as bit6 while that byte is at the head.
- R5: With bit1 = 1 and bit3 = 1, a frame whose ninth bit is 0 is dropped without a trace, and a frame whose ninth bit is 1 is stored and raises irq. With bit1 = 0, bit3 has no effect.
- R6: With bit3 = 0, every frame is stored, and its ninth bit passes through unchanged with no parity check.
- R7: A stop bit that samples low marks the entry as framed badly. Bit4 shows the marker of the head entry, so it changes when that entry is popped and the next one becomes the head.
- R8: A frame that completes while the queue holds two entries sets bit5 and is lost. While bit5 is 1, no frame is loaded. Bit5 clears only when the continuous-receive bit is 0.
- R9: A start bit is accepted only if the line is still low at the 8th tick. A shorter low pulse returns the receiver to idle, and nothing is loaded.
- R10: Each data bit is the majority of three samples taken at mid-bit, so a low or high glitch lasting one tick does not change the received value.
- R11: irq is high exactly while the queue is non-empty. It drops after the last entry is popped with rd_strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversampling strobe, 16 per bit time |
| rx_in | input | 1 | Asynchronous serial input, idle high |
| reg_we | input | 1 | Write strobe for the control bits |
| reg_wdata | input | 4 | Control bits to write |
| reg_rdata | output | 8 | Control and status word |
| rd_strobe | input | 1 | Pops the head queue entry |
| rx_data | output | 8 | Data byte at the queue head |
| irq | output | 1 | Receive request, high while the queue is non-empty |

## Verification
On every cycle the assertions check these rules: irq only falls right after a pop, and it only rises when the port was enabled and not in overrun. A framing error is never shown without queued data. Overrun only clears after continuous reception has been turned off. Other behaviour can only be shown by the bench's directed frames: bit order, ninth-bit storage, address filtering, loss of the frame that overflows, rejection of a short start pulse and majority voting across a one-tick glitch.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_state_t;

  typedef struct packed {
    logic       bad_stop;
    logic       bit9;
    logic [7:0] data;
  } rx_entry_t;
endpackage

// File: rtl/uart9_deser.sv
module uart9_deser
  import uart9_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       tick,
  input  logic       rx,
  input  logic       wide,
  output logic       done,
  output logic [7:0] data,
  output logic       bit9,
  output logic       bad_stop
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] C_MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] C_MID1 = CW'(OVS/2);
  localparam logic [CW-1:0] C_MID2 = CW'(OVS/2 + 1);
  localparam logic [CW-1:0] C_LAST = CW'(OVS - 1);

  rx_state_t      st;
  logic [CW-1:0]  cnt;
  logic [3:0]     idx;
  logic [8:0]     sr;
  logic [1:0]     vote;
  logic           maj;
  logic [CW-1:0]  cnt_nx;

  assign maj    = (vote[0] & vote[1]) | (vote[0] & rx) | (vote[1] & rx);
  assign cnt_nx = (cnt == C_LAST) ? '0 : cnt + 1'b1;
  assign data   = wide ? sr[7:0] : sr[8:1];
  assign bit9   = wide & sr[8];

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      st       <= S_IDLE;
      cnt      <= '0;
      idx      <= '0;
      vote     <= '0;
      done     <= 1'b0;
      bad_stop <= 1'b0;
      if (rst) sr <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (st == S_DATA || st == S_STOP) begin
          if (cnt == C_MID)  vote[0] <= rx;
          if (cnt == C_MID1) vote[1] <= rx;
        end
        case (st)
          S_IDLE: if (!rx) begin
            st  <= S_START;
            cnt <= CW'(1);
          end
          S_START: begin
            cnt <= cnt_nx;
            if (cnt == C_MID && rx) st <= S_IDLE;
            else if (cnt == C_LAST) begin
              st  <= S_DATA;
              idx <= '0;
            end
          end
          S_DATA: begin
            cnt <= cnt_nx;
            if (cnt == C_MID2) sr <= {maj, sr[8:1]};
            if (cnt == C_LAST) begin
              if (idx == (wide ? 4'd8 : 4'd7)) st <= S_STOP;
              else idx <= idx + 1'b1;
            end
          end
          S_STOP: begin
            cnt <= cnt_nx;
            if (cnt == C_MID2) begin
              done     <= 1'b1;
              bad_stop <= ~maj;
              st       <= S_IDLE;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart9_fifo.sv
module uart9_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] count;
  logic            do_wr, do_rd;

  assign empty = (count == '0);
  assign full  = (count == CNTW'(DEPTH));
  assign do_wr = push & ~full;
  assign do_rd = pop & ~empty;
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
  import uart9_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DEPTH       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick16,
  input  logic       rx_in,
  input  logic       reg_we,
  input  logic [3:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rd_strobe,
  output logic [7:0] rx_data,
  output logic       irq
);
  localparam int EW = $bits(rx_entry_t);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [3:0]  ctl;
  logic        ovr;
  logic        rx_s, run, keep, push;
  logic        f_done, f_b9, f_bad;
  logic [7:0]  f_data;
  rx_entry_t   wr_ent, hd_ent;
  logic [EW-1:0] hd_raw;
  logic        q_empty, q_full;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
  end
  assign rx_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst)         ctl <= '0;
    else if (reg_we) ctl <= reg_wdata;
  end

  assign run  = ctl[0] & ctl[2] & ~ovr;
  assign keep = ~(ctl[1] & ctl[3] & ~f_b9);
  assign push = f_done & keep & ~q_full;

  always_ff @(posedge clk) begin
    if (rst || !ctl[2])                ovr <= 1'b0;
    else if (f_done && keep && q_full) ovr <= 1'b1;
  end

  uart9_deser #(.OVS(OVS)) u_deser (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .tick     (tick16),
    .rx       (rx_s),
    .wide     (ctl[1]),
    .done     (f_done),
    .data     (f_data),
    .bit9     (f_b9),
    .bad_stop (f_bad)
  );

  assign wr_ent = '{bad_stop: f_bad, bit9: f_b9, data: f_data};

  uart9_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .wdata (wr_ent),
    .pop   (rd_strobe),
    .head  (hd_raw),
    .empty (q_empty),
    .full  (q_full)
  );

  assign hd_ent    = rx_entry_t'(hd_raw);
  assign rx_data   = hd_ent.data;
  assign irq       = ~q_empty;
  assign reg_rdata = {1'b0, hd_ent.bit9, ovr, hd_ent.bad_stop & ~q_empty, ctl};
endmodule

// File: rtl/uart9_rx_chk.sv
module uart9_rx_chk (
  input logic       clk,
  input logic       rst,
  input logic       irq,
  input logic       rd_strobe,
  input logic [7:0] reg_rdata
);
  p_irq_falls_on_read_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(rd_strobe));

  p_capture_enabled_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(reg_rdata[0] && reg_rdata[2] && !reg_rdata[5]));

  p_ferr_has_data_r7: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[4] |-> irq);

  p_ovr_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(reg_rdata[5]) |-> !$past(reg_rdata[2]));

  p_ovr_blocks_load_r8: assert property (@(posedge clk) disable iff (rst)
    $past(reg_rdata[5]) && reg_rdata[5] |-> !$rose(irq));
endmodule

bind uart9_rx uart9_rx_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq       (irq),
  .rd_strobe (rd_strobe),
  .reg_rdata (reg_rdata)
);

// File: tb/test_uart9_rx.sv
`timescale 1ns/1ps
module test_uart9_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_in = 1'b1;
  logic       reg_we = 1'b0;
  logic [3:0] reg_wdata = '0;
  logic       rd_strobe = 1'b0;
  logic [7:0] reg_rdata, rx_data;
  logic       irq, tick16;
  logic [1:0] tdiv = '0;
  int errors = 0;
  int checks = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;
  always_ff @(posedge clk) tdiv <= tdiv + 1'b1;
  assign tick16 = (tdiv == 2'd3);

  uart9_rx i_uart9_rx (
    .clk(clk), .rst(rst), .tick16(tick16), .rx_in(rx_in),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rd_strobe(rd_strobe), .rx_data(rx_data), .irq(irq)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(int n);
    for (int k = 0; k < n; k++) begin
      do @(negedge clk); while (!tick16);
      @(negedge clk);
    end
  endtask

  task automatic set_ctl(logic [3:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic pop();
    @(negedge clk);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(int nb, logic [8:0] v, logic stopv = 1'b1, int gbit = -1);
    rx_in = 1'b0;
    wait_ticks(16);
    for (int i = 0; i < nb; i++) begin
      if (i == gbit) begin
        rx_in = v[i];  wait_ticks(8);
        rx_in = ~v[i]; wait_ticks(1);
        rx_in = v[i];  wait_ticks(7);
      end else begin
        rx_in = v[i];
        wait_ticks(16);
      end
    end
    rx_in = stopv;
    wait_ticks(16);
    rx_in = 1'b1;
    wait_ticks(6);
  endtask

  task automatic t_reset();
    check("R1 status after reset", reg_rdata[5:0], 0);
    check("R1 irq after reset", irq, 0);
    set_ctl(4'b1010);
    check("R1 control readback", reg_rdata[3:0], 4'b1010);
    set_ctl(4'b0000);
  endtask

  task automatic t_disabled();
    set_ctl(4'b0100);
    send(8, 9'h0A5);
    check("R2 port off loads nothing", irq, 0);
    set_ctl(4'b0001);
    send(8, 9'h05A);
    check("R2 continuous off loads nothing", irq, 0);
  endtask

  task automatic t_byte8();
    set_ctl(4'b0101);
    send(8, 9'h0A5);
    check("R3 irq after frame", irq, 1);
    check("R3 byte LSB first", rx_data, 8'hA5);
    send(8, 9'h03C);
    pop();
    check("R11 irq with one left", irq, 1);
    check("R3 second byte", rx_data, 8'h3C);
    pop();
    check("R11 irq after last pop", irq, 0);
  endtask

  task automatic t_nine();
    set_ctl(4'b0111);
    send(9, 9'h1A5);
    send(9, 9'h05A);
    check("R4 data of 9-bit frame", rx_data, 8'hA5);
    check("R4 ninth bit set", reg_rdata[6], 1);
    pop();
    check("R6 frame with ninth bit 0 kept", rx_data, 8'h5A);
    check("R6 ninth bit passed", reg_rdata[6], 0);
    pop();
  endtask

  task automatic t_addr();
    set_ctl(4'b1111);
    send(9, 9'h033);
    check("R5 data frame dropped", irq, 0);
    send(9, 9'h1C4);
    check("R5 address frame raises irq", irq, 1);
    check("R5 address byte", rx_data, 8'hC4);
    check("R5 address ninth bit", reg_rdata[6], 1);
    pop();
    set_ctl(4'b1101);
    send(8, 9'h012);
    check("R5 filter ignored in 8-bit mode", rx_data, 8'h12);
    pop();
    check("R5 queue emptied", irq, 0);
  endtask

  task automatic t_ferr();
    set_ctl(4'b0101);
    send(8, 9'h011, 1'b0);
    send(8, 9'h022);
    check("R7 framing error on head", reg_rdata[4], 1);
    check("R7 bad frame data kept", rx_data, 8'h11);
    pop();
    check("R7 flag follows new head", reg_rdata[4], 0);
    check("R7 next data", rx_data, 8'h22);
    pop();
    check("R7 no flag when empty", reg_rdata[4], 0);
  endtask

  task automatic t_overrun();
    set_ctl(4'b0101);
    send(8, 9'h001);
    send(8, 9'h002);
    check("R8 no overrun while fitting", reg_rdata[5], 0);
    send(8, 9'h003);
    check("R8 overrun set", reg_rdata[5], 1);
    send(8, 9'h004);
    check("R8 head unchanged", rx_data, 8'h01);
    pop();
    check("R8 second entry", rx_data, 8'h02);
    pop();
    check("R8 overflowing frames lost", irq, 0);
    check("R8 overrun survives pops", reg_rdata[5], 1);
    set_ctl(4'b0001);
    check("R8 overrun cleared by continuous off", reg_rdata[5], 0);
    set_ctl(4'b0101);
    send(8, 9'h005);
    check("R8 reception resumes", rx_data, 8'h05);
    pop();
  endtask

  task automatic t_glitch();
    set_ctl(4'b0101);
    rx_in = 1'b0;
    wait_ticks(3);
    rx_in = 1'b1;
    wait_ticks(24);
    check("R9 short start rejected", irq, 0);
    send(8, 9'h069);
    check("R9 receiver recovers", rx_data, 8'h69);
    pop();
  endtask

  task automatic t_vote();
    set_ctl(4'b0101);
    send(8, 9'h00F, 1'b1, 0);
    check("R10 glitch on bit 0 voted out", rx_data, 8'h0F);
    pop();
    send(8, 9'h00F, 1'b1, 5);
    check("R10 glitch on bit 5 voted out", rx_data, 8'h0F);
    pop();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_byte8();
    t_nine();
    t_addr();
    t_ferr();
    t_overrun();
    t_glitch();
    t_vote();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done_flag) begin
      done_flag = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule